// File: doc/BRIEF.md
# Byte-Handshake Host Bus Slave

This block is the clocked-logic end of an 8-bit parallel link to an external microcontroller. The host frames each exchange with a start pulse. It then sends a six-byte command, one byte per four-phase handshake. The block turns the command into a single access on an internal register port. It then hands back an eight-byte reply made of a result word and a status word. Every control input from the host is asynchronous to the system clock, so each one passes through a two-flop synchroniser before the controller acts on it.

On each byte the two handshake wires swap roles with the transfer direction. When the host sends, it raises its strobe first and the block answers. When the host receives, the block presents the byte and raises its strobe first, and the host answers. A busy line stays high from the start pulse to the end of the reply. The block drives the data bus only while it is replying and the host has selected read. At all other times the bus is left high-impedance.

Top module: `hbus_slave`

## Requirements
- R1: A transaction opens only when `host_start` rises and then falls (each level held at least two clock periods). `host_busy` goes high on the third rising clock edge after `host_start` falls, and does not go high while `host_start` is only held high.
- R2: While `host_rst_n` is low, the block returns to idle. `host_hs2` and `host_busy` are low from the third rising edge after `host_rst_n` falls. After `host_rst_n` returns high, the next transaction completes normally.
- R3: Host-to-slave byte (`host_rw` = 0): after `host_hs1` rises, the block latches `host_din` and raises `host_hs2`. `host_hs2` stays high until `host_hs1` falls, then drops on the third rising edge after that fall.
- R4: Slave-to-host byte (`host_rw` = 1): the block drives the byte and raises `host_hs2` while `host_hs1` is low. `host_hs2` stays high until `host_hs1` rises, then drops on the third rising edge after that rise.
- R5: The command is six bytes: byte 0 is the opcode, byte 1 is the register address, and bytes 2..5 are the 32-bit write word, least significant byte first. A write stores that word at that address.
- R6: The reply is eight bytes: bytes 0..3 are the result word and bytes 4..7 are the status word, each least significant byte first. A successful read returns the register contents. A successful write returns zero.
- R7: `host_busy` stays high for the whole transaction. It falls on the third rising edge after `host_hs1` falls at the end of the last reply byte.
- R8: Opcode 0x01 is a register write and opcode 0x02 is a register read. A valid access reports status 0.
- R9: Any other opcode produces the full reply with status 1 and result 0, and causes no register access. This takes precedence over an address error.
- R10: An address of `NUM_REGS` or above produces status 2 and result 0, and causes no register access.
- R11: `host_oe` is high only while the block is in its reply phase and `host_rw` = 1. It is low while the command is received and while idle.
- R12: After the sixth command byte, a valid command issues exactly one single-cycle `reg_wr` or `reg_rd` strobe. `reg_rdata` is sampled on the clock after `reg_rd`, before the first reply byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| host_rst_n | input | 1 | Asynchronous host reset, active low |
| host_start | input | 1 | Asynchronous transaction start strobe |
| host_rw | input | 1 | Asynchronous direction select, 1 = host reads |
| host_hs1 | input | 1 | Asynchronous host handshake strobe |
| host_din | input | 8 | Data bus value seen from the pins |
| host_dout | output | 8 | Data bus value to drive in reply |
| host_oe | output | 1 | Data bus output enable |
| host_hs2 | output | 1 | Slave handshake strobe |
| host_busy | output | 1 | Transaction in progress |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid one clock after `reg_rd` |

## Verification
Every response to a host input goes through the two synchroniser flops and then one state register. So `host_busy` rising after a start fall, each `host_hs2` fall, `host_busy` falling after the last byte, and the clearing on host reset are all due on the third rising edge after the input changes. The bench drives inputs on falling edges. It checks the old value after two rising edges and the new value after the third, so a lost or extra register stage shows up as a timing mismatch. Reply contents and strobe counts are compared per transaction against a model computed from the opcode, the address and a shadow copy of the register file. Directed cases cover the edge addresses, bad opcodes, a held start line and a host reset in the middle of a command.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    // Packet geometry and widths shared by the slave modules.
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int CMD_BYTES = 6;
    localparam int RPL_BYTES = 8;

    // Opcodes carried in command byte 0.
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h01;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h02;

    // Status codes returned in the reply status word.
    localparam logic [WORD_W-1:0] ST_OK       = 32'd0;
    localparam logic [WORD_W-1:0] ST_BAD_OP   = 32'd1;
    localparam logic [WORD_W-1:0] ST_BAD_ADDR = 32'd2;

    // Controller phases.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX_WAIT,
        PH_RX_ACK,
        PH_EXEC,
        PH_CAPTURE,
        PH_TX_SETUP,
        PH_TX_ACK,
        PH_TX_TAIL
    } phase_t;
endpackage

// File: rtl/hbus_sync.sv
// hbus_sync: two-flop synchroniser, one independent chain per bit.
// Assumes each input is a level that stays stable for at least two clocks.
// RST_VAL gives the value each chain holds during system reset.
module hbus_sync #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_chain
        logic meta_q;
        logic stab_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/hbus_engine.sv
// hbus_engine: packet controller for the byte-handshake host bus.
// Assumes all host control inputs are already synchronised. It assumes
// host_din is stable while the synchronised hs1 is high in write direction.
// It collects a six-byte command, issues one register access and serialises
// an eight-byte reply.
module hbus_engine
    import hbus_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_start,
    input  logic              s_rw,
    input  logic              s_hs1,
    input  logic              s_brst_n,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              hs2,
    output logic              busy,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    localparam int CMD_W = CMD_BYTES * BYTE_W;
    localparam int RPL_W = RPL_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(RPL_BYTES);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BYTES - 1);
    localparam logic [CNT_W-1:0] RPL_LAST = CNT_W'(RPL_BYTES - 1);

    phase_t             phase;
    logic               start_d;
    logic [CNT_W-1:0]   byte_cnt;
    logic [CMD_W-1:0]   cmd_sr;
    logic [RPL_W-1:0]   rpl_sr;
    logic [BYTE_W-1:0]  opcode;
    logic [BYTE_W-1:0]  addr_byte;
    logic [WORD_W-1:0]  status_c;
    logic               start_fall;
    logic               access_ok;

    assign start_fall = start_d && !s_start;
    assign opcode     = cmd_sr[BYTE_W-1:0];
    assign addr_byte  = cmd_sr[BYTE_W +: BYTE_W];
    assign reg_addr   = cmd_sr[BYTE_W +: ADDR_W];
    assign reg_wdata  = cmd_sr[2*BYTE_W +: WORD_W];
    assign bus_dout   = rpl_sr[BYTE_W-1:0];

    // Decode the received command into a status code.
    always_comb begin
        if (opcode != OP_WRITE && opcode != OP_READ) begin
            status_c = ST_BAD_OP;
        end else if (int'(addr_byte) >= NUM_REGS) begin
            status_c = ST_BAD_ADDR;
        end else begin
            status_c = ST_OK;
        end
    end
    assign access_ok = (status_c == ST_OK);

    // Register-port strobes, one cycle in the execute phase.
    assign reg_wr = (phase == PH_EXEC) && access_ok && (opcode == OP_WRITE);
    assign reg_rd = (phase == PH_EXEC) && access_ok && (opcode == OP_READ);

    // Drive the data bus only during the reply with read selected.
    assign bus_oe = s_rw && (phase == PH_TX_SETUP || phase == PH_TX_ACK ||
                             phase == PH_TX_TAIL);

    // Main sequencer: start detection, byte handshakes, access and reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            start_d  <= 1'b0;
            hs2      <= 1'b0;
            busy     <= 1'b0;
            byte_cnt <= '0;
            cmd_sr   <= '0;
            rpl_sr   <= '0;
        end else begin
            start_d <= s_start;
            if (!s_brst_n) begin
                phase    <= PH_IDLE;
                hs2      <= 1'b0;
                busy     <= 1'b0;
                byte_cnt <= '0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (start_fall) begin
                            phase    <= PH_RX_WAIT;
                            busy     <= 1'b1;
                            byte_cnt <= '0;
                        end
                    end
                    PH_RX_WAIT: begin
                        if (s_hs1 && !s_rw) begin
                            cmd_sr <= {bus_din, cmd_sr[CMD_W-1:BYTE_W]};
                            hs2    <= 1'b1;
                            phase  <= PH_RX_ACK;
                        end
                    end
                    PH_RX_ACK: begin
                        if (!s_hs1) begin
                            hs2 <= 1'b0;
                            if (byte_cnt == CMD_LAST) begin
                                byte_cnt <= '0;
                                phase    <= PH_EXEC;
                            end else begin
                                byte_cnt <= byte_cnt + 1'b1;
                                phase    <= PH_RX_WAIT;
                            end
                        end
                    end
                    PH_EXEC: begin
                        phase <= PH_CAPTURE;
                    end
                    PH_CAPTURE: begin
                        rpl_sr <= {status_c,
                                   (access_ok && opcode == OP_READ) ? reg_rdata : '0};
                        phase  <= PH_TX_SETUP;
                    end
                    PH_TX_SETUP: begin
                        if (s_rw && !s_hs1) begin
                            hs2   <= 1'b1;
                            phase <= PH_TX_ACK;
                        end
                    end
                    PH_TX_ACK: begin
                        if (s_hs1) begin
                            hs2    <= 1'b0;
                            rpl_sr <= {{BYTE_W{1'b0}}, rpl_sr[RPL_W-1:BYTE_W]};
                            if (byte_cnt == RPL_LAST) begin
                                phase <= PH_TX_TAIL;
                            end else begin
                                byte_cnt <= byte_cnt + 1'b1;
                                phase    <= PH_TX_SETUP;
                            end
                        end
                    end
                    PH_TX_TAIL: begin
                        if (!s_hs1) begin
                            busy  <= 1'b0;
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R2
    host_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_brst_n |=> (!hs2 && !busy));
    // R3
    hs2_rise_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs2) |-> busy);
    // R7
    busy_drop_idle_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !hs2);
    // R11
    oe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> busy);
    // R12
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R12
    wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R12
    rd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
endmodule

// File: rtl/hbus_slave.sv
// hbus_slave: top of the byte-handshake host bus slave.
// Assumes the host holds each control level for at least two clocks.
// Synchronises the host control lines and hands them to the packet engine.
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_n,
    input  logic              host_start,
    input  logic              host_rw,
    input  logic              host_hs1,
    input  logic [7:0]        host_din,
    output logic [7:0]        host_dout,
    output logic              host_oe,
    output logic              host_hs2,
    output logic              host_busy,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);
    localparam int NSYNC = 4;
    logic [NSYNC-1:0] ctl_sync;

    // Bit 3 (host reset) idles high so a system reset alone keeps the engine usable.
    hbus_sync #(.WIDTH(NSYNC), .RST_VAL(4'b1000)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_rst_n, host_hs1, host_rw, host_start}),
        .sync_o  (ctl_sync)
    );

    hbus_engine #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_start   (ctl_sync[0]),
        .s_rw      (ctl_sync[1]),
        .s_hs1     (ctl_sync[2]),
        .s_brst_n  (ctl_sync[3]),
        .bus_din   (host_din),
        .bus_dout  (host_dout),
        .bus_oe    (host_oe),
        .hs2       (host_hs2),
        .busy      (host_busy),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/sim_hbus_slave.sv
module sim_hbus_slave;
    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rst_n = 1'b1;
    logic          host_start = 1'b0;
    logic          host_rw = 1'b0;
    logic          host_hs1 = 1'b0;
    logic [7:0]    host_din = 8'h00;
    logic [7:0]    host_dout;
    logic          host_oe;
    logic          host_hs2;
    logic          host_busy;
    logic          reg_wr;
    logic          reg_rd;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata = 32'h0;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int wr_pulses = 0;
    int rd_pulses = 0;
    logic [31:0] mem    [NREG];
    logic [31:0] shadow [NREG];

    always #10 clk = ~clk;

    hbus_slave #(.NUM_REGS(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n),
        .host_start(host_start), .host_rw(host_rw), .host_hs1(host_hs1),
        .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe),
        .host_hs2(host_hs2), .host_busy(host_busy),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register file behind the port: one-cycle read latency.
    always @(posedge clk) begin
        if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_pulses <= wr_pulses + 1; end
        if (reg_rd) begin reg_rdata <= mem[reg_addr]; rd_pulses <= rd_pulses + 1; end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_hs2(input logic lvl, input string req);
        int n = 0;
        while (host_hs2 !== lvl && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) chk(req, {63'd0, host_hs2}, {63'd0, lvl});
    endtask

    // Host-to-slave byte with timing checks on the hs2 release.
    task automatic send_byte(input logic [7:0] b);
        host_din = b; host_rw = 1'b0; host_hs1 = 1'b1;
        wait_hs2(1'b1, "R3 hs2 rise");
        chk("R11 oe low in command phase", {63'd0, host_oe}, 64'd0);
        cyc(3);
        chk("R3 hs2 held while hs1 high", {63'd0, host_hs2}, 64'd1);
        host_hs1 = 1'b0;
        cyc(2);
        chk("R3 hs2 before release", {63'd0, host_hs2}, 64'd1);
        cyc(1);
        chk("R3 hs2 release edge", {63'd0, host_hs2}, 64'd0);
    endtask

    // Slave-to-host byte with timing checks on the hs2 release.
    task automatic recv_byte(output logic [7:0] b);
        host_rw = 1'b1;
        wait_hs2(1'b1, "R4 hs2 rise");
        chk("R11 oe high in reply", {63'd0, host_oe}, 64'd1);
        b = host_dout;
        host_hs1 = 1'b1;
        cyc(2);
        chk("R4 hs2 before release", {63'd0, host_hs2}, 64'd1);
        cyc(1);
        chk("R4 hs2 release edge", {63'd0, host_hs2}, 64'd0);
        host_hs1 = 1'b0;
    endtask

    task automatic open_txn;
        host_start = 1'b1;
        cyc(4);
        host_start = 1'b0;
        cyc(2);
        chk("R1 busy before edge", {63'd0, host_busy}, 64'd0);
        cyc(1);
        chk("R1 busy after start fall", {63'd0, host_busy}, 64'd1);
    endtask

    // One full transaction checked against the bench model.
    task automatic txn(input logic [7:0] op, input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] exp_st, exp_d, got_st, got_d;
        logic [7:0]  b;
        int          exp_wr, exp_rd;
        if (op != 8'h01 && op != 8'h02)  exp_st = 32'd1;   // R9
        else if (int'(addr) >= NREG)     exp_st = 32'd2;   // R10
        else                             exp_st = 32'd0;   // R8
        exp_d  = (exp_st == 0 && op == 8'h02) ? shadow[addr[AW-1:0]] : 32'd0;
        exp_wr = (exp_st == 0 && op == 8'h01) ? 1 : 0;
        exp_rd = (exp_st == 0 && op == 8'h02) ? 1 : 0;
        wr_pulses = 0; rd_pulses = 0;
        open_txn();
        send_byte(op); send_byte(addr);
        for (int k = 0; k < 4; k++) send_byte(wd[8*k +: 8]);
        got_d = '0; got_st = '0;
        for (int k = 0; k < 4; k++) begin recv_byte(b); got_d[8*k +: 8] = b; end
        for (int k = 0; k < 4; k++) begin
            recv_byte(b); got_st[8*k +: 8] = b;
            if (k < 3) chk("R7 busy during reply", {63'd0, host_busy}, 64'd1);
        end
        cyc(2);
        chk("R7 busy before end edge", {63'd0, host_busy}, 64'd1);
        cyc(1);
        chk("R7 busy falls after last byte", {63'd0, host_busy}, 64'd0);
        host_rw = 1'b0;
        chk("R6 reply data word", {32'd0, got_d}, {32'd0, exp_d});
        chk("R8 R9 R10 status word", {32'd0, got_st}, {32'd0, exp_st});
        chk("R12 write strobe count", 64'(wr_pulses), 64'(exp_wr));
        chk("R12 read strobe count", 64'(rd_pulses), 64'(exp_rd));
        if (exp_wr == 1) begin
            chk("R5 stored word", {32'd0, mem[addr[AW-1:0]]}, {32'd0, wd});
            shadow[addr[AW-1:0]] = wd;
        end
        cyc(2);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mem[i] = 32'hC0DE0000 + 32'(i * 3);
            shadow[i] = 32'hC0DE0000 + 32'(i * 3);
        end
        void'($urandom(32'd4242));
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        chk("R2 reset hs2", {63'd0, host_hs2}, 64'd0);
        chk("R2 reset busy", {63'd0, host_busy}, 64'd0);
        chk("R11 reset oe", {63'd0, host_oe}, 64'd0);
        host_rw = 1'b1;
        cyc(4);
        chk("R11 oe low when idle with read", {63'd0, host_oe}, 64'd0);
        host_rw = 1'b0;

        // R1: a held start line alone opens nothing.
        host_start = 1'b1;
        cyc(8);
        chk("R1 no busy while start held", {63'd0, host_busy}, 64'd0);
        host_start = 1'b0;
        cyc(3);
        chk("R1 busy after late fall", {63'd0, host_busy}, 64'd1);
        // R2: host reset in mid-command.
        send_byte(8'h01);
        host_rst_n = 1'b0;
        cyc(2);
        chk("R2 busy before reset edge", {63'd0, host_busy}, 64'd1);
        cyc(1);
        chk("R2 busy cleared by host reset", {63'd0, host_busy}, 64'd0);
        chk("R2 hs2 cleared by host reset", {63'd0, host_hs2}, 64'd0);
        cyc(5);
        host_rst_n = 1'b1;
        cyc(4);

        // Directed corner cases.
        txn(8'h01, 8'(NREG - 1), 32'hA5A5_0F0F);  // R5 last valid address
        txn(8'h02, 8'(NREG - 1), 32'h0);          // R6 read back
        txn(8'h02, 8'd0, 32'hFFFF_FFFF);          // R6 read of initial value
        txn(8'h01, 8'(NREG), 32'h1234_5678);      // R10 first invalid address
        txn(8'h02, 8'hFF, 32'h0);                 // R10
        txn(8'h00, 8'd3, 32'h1);                  // R9
        txn(8'h7E, 8'hF0, 32'h2);                 // R9 over R10

        // Constrained random mix.
        for (int t = 0; t < 40; t++) begin
            int r = int'($urandom % 8);
            logic [7:0] op;
            logic [7:0] ad = 8'($urandom % (NREG + 4));
            if (r < 3)      op = 8'h01;
            else if (r < 6) op = 8'h02;
            else begin
                op = 8'($urandom);
                if (op == 8'h01 || op == 8'h02) op = 8'h80;
            end
            txn(op, ad, $urandom);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule